// File: doc/BRIEF.md
# Output Port Virtual-Channel and Credit Tracker

This block keeps, for one output port of a router, two pieces of state for every downstream virtual channel (VC). The first is whether the VC is idle or held by a packet. The second is how many buffer slots the downstream router still has free for that VC. The VCs are split into virtual networks (vnets) of equal size. A head flit that needs a VC asks for one inside its own vnet. The tracker tells it at once whether one is free, names the lowest-numbered idle VC of that vnet, and marks that VC busy at the clock edge.

Every switch grant to a VC uses up one credit. Credits that the downstream router returns add one back. A returned credit may also carry a release flag, which puts the VC back to idle. Per-VC credit availability is reported as a vector, so the switch allocator can tell whether a body or tail flit may be sent. A counter that would go below zero or above the buffer depth is not changed, and an error pulse is raised instead.

Top module: `vc_credit_tracker`

## Requirements
- R1: Out of reset, every VC is idle and holds BUF_DEPTH credits: `vc_busy` is all zero, `vc_has_credit` and `vnet_has_free` are all ones, and `credit_err` is low.
- R2: Vnet n owns VC indices n*VCS_PER_VNET to n*VCS_PER_VNET+VCS_PER_VNET-1. A granted `alloc_vc` always lies in the range of `alloc_vnet`.
- R3: `vnet_has_free[n]` is high in the same cycle exactly when at least one VC of vnet n is idle.
- R4: `alloc_gnt` is high in the same cycle exactly when `alloc_req` is high and the requested vnet has an idle VC. `alloc_vc` is then the lowest idle index of that vnet.
- R5: A granted allocation makes the chosen VC busy from the next cycle on, so that VC is not offered again until it is released.
- R6: `sw_grant` lowers the credit count of `sw_grant_vc` by one at the next clock edge.
- R7: `cr_valid` raises the credit count of `cr_vc` by one. When `cr_free` is also high, that VC becomes idle at the next edge. If an allocation picks the same VC in the same cycle, the allocation wins.
- R8: `vc_has_credit[v]` is high exactly when the credit count of VC v is one or more.
- R9: A decrement and an increment of the same VC in the same cycle leave its count unchanged and raise no error, including at zero and at BUF_DEPTH.
- R10: A lone decrement at zero, or a lone increment at BUF_DEPTH, leaves the count unchanged. It sets `credit_err` high for the one cycle after the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Request for a free VC |
| alloc_vnet | input | VNET_W | Vnet of the request |
| alloc_gnt | output | 1 | A free VC was found; it is taken at the edge |
| alloc_vc | output | VC_W | Index of the VC handed out |
| vnet_has_free | output | NUM_VNETS | Per-vnet idle-VC indication |
| sw_grant | input | 1 | Switch grant; consumes one credit |
| sw_grant_vc | input | VC_W | VC charged by the switch grant |
| cr_valid | input | 1 | Credit returned from downstream |
| cr_vc | input | VC_W | VC the credit belongs to |
| cr_free | input | 1 | Returned credit also releases the VC |
| vc_has_credit | output | NUM_VCS | Per-VC credit count is non-zero |
| vc_busy | output | NUM_VCS | Per-VC held flag |
| credit_err | output | 1 | Underflow or overflow in the previous cycle |

## Verification
The properties assume that VC indices on `sw_grant_vc` and `cr_vc` are below NUM_VCS whenever their strobes are high. Those that look at release or underflow exclude same-cycle collisions on one VC, since the requirements give those cases their own rule. The random stimulus only ever draws in-range VC indices and vnets. It mixes switch grants and credit returns at equal rates, so counts move through zero and full without staying there, and releases land on both busy and idle VCs. Directed steps push each count over its limits on purpose, then collide an increment with a decrement on the same VC at zero.

// File: rtl/vct_pkg.sv
package vct_pkg;
  // Width helper: at least one bit for an index into n items.
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Credit counter update request, decoded from the two strobes.
  typedef enum logic [1:0] {
    CR_HOLD = 2'b00,
    CR_DEC  = 2'b01,
    CR_INC  = 2'b10,
    CR_BOTH = 2'b11
  } cr_op_e;
endpackage

// File: rtl/vct_free_pick.sv
// Lowest-index-first search over the idle flags of one vnet.
module vct_free_pick #(
  parameter int unsigned K   = 2,
  parameter int unsigned K_W = 1
) (
  input  logic [K-1:0]   idle,
  output logic           any,
  output logic [K_W-1:0] pick
);
  always_comb begin
    any  = 1'b0;
    pick = '0;
    for (int i = K - 1; i >= 0; i--) begin
      if (idle[i]) begin
        any  = 1'b1;
        pick = K_W'(i);
      end
    end
  end
endmodule

// File: rtl/vct_vc_slot.sv
// State of one downstream VC: held flag and credit counter.
module vct_vc_slot
  import vct_pkg::*;
#(
  parameter int unsigned BUF_DEPTH = 4,
  parameter int unsigned CNT_W     = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic release_vc,
  input  logic dec,
  input  logic inc,
  output logic busy,
  output logic has_credit,
  output logic under,
  output logic over
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BUF_DEPTH);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             en;
  cr_op_e           op;

  assign op = cr_op_e'({inc, dec});

  always_comb begin
    cnt_d = cnt_q;
    under = 1'b0;
    over  = 1'b0;
    unique case (op)
      CR_INC: begin
        if (cnt_q == FULL) over = 1'b1;
        else               cnt_d = cnt_q + 1'b1;
      end
      CR_DEC: begin
        if (cnt_q == '0) under = 1'b1;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: cnt_d = cnt_q;
    endcase
  end

  always_comb begin
    busy_d = busy_q;
    if (release_vc) busy_d = 1'b0;
    if (take)       busy_d = 1'b1;
  end

  assign en = take | release_vc | inc | dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= FULL;
      busy_q <= 1'b0;
    end else if (en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy       = busy_q;
  assign has_credit = (cnt_q != '0);
endmodule

// File: rtl/vc_credit_tracker.sv
module vc_credit_tracker
  import vct_pkg::*;
#(
  parameter int unsigned NUM_VNETS    = 3,
  parameter int unsigned VCS_PER_VNET = 2,
  parameter int unsigned BUF_DEPTH    = 4,
  localparam int unsigned NUM_VCS = NUM_VNETS * VCS_PER_VNET,
  localparam int unsigned VNET_W  = idx_w(NUM_VNETS),
  localparam int unsigned VC_W    = idx_w(NUM_VCS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alloc_req,
  input  logic [VNET_W-1:0]    alloc_vnet,
  output logic                 alloc_gnt,
  output logic [VC_W-1:0]      alloc_vc,
  output logic [NUM_VNETS-1:0] vnet_has_free,
  input  logic                 sw_grant,
  input  logic [VC_W-1:0]      sw_grant_vc,
  input  logic                 cr_valid,
  input  logic [VC_W-1:0]      cr_vc,
  input  logic                 cr_free,
  output logic [NUM_VCS-1:0]   vc_has_credit,
  output logic [NUM_VCS-1:0]   vc_busy,
  output logic                 credit_err
);
  localparam int unsigned K_W   = idx_w(VCS_PER_VNET);
  localparam int unsigned CNT_W = $clog2(BUF_DEPTH + 1);

  logic [K_W-1:0]     pick [NUM_VNETS];
  logic [NUM_VCS-1:0] under_v, over_v;
  logic               err_d, err_q;

  // One priority search per vnet partition.
  for (genvar n = 0; n < NUM_VNETS; n++) begin : g_vnet
    vct_free_pick #(.K(VCS_PER_VNET), .K_W(K_W)) u_pick (
      .idle (~vc_busy[n*VCS_PER_VNET +: VCS_PER_VNET]),
      .any  (vnet_has_free[n]),
      .pick (pick[n])
    );
  end

  // Route the requested vnet's answer to the allocation outputs.
  always_comb begin
    alloc_gnt = 1'b0;
    alloc_vc  = '0;
    for (int n = 0; n < NUM_VNETS; n++) begin
      if (alloc_vnet == VNET_W'(n)) begin
        alloc_gnt = alloc_req & vnet_has_free[n];
        alloc_vc  = VC_W'(n * VCS_PER_VNET) + VC_W'(pick[n]);
      end
    end
  end

  for (genvar v = 0; v < NUM_VCS; v++) begin : g_vc
    logic take_v, rel_v, dec_v, inc_v;
    assign take_v = alloc_gnt & (alloc_vc == VC_W'(v));
    assign inc_v  = cr_valid & (cr_vc == VC_W'(v));
    assign rel_v  = inc_v & cr_free;
    assign dec_v  = sw_grant & (sw_grant_vc == VC_W'(v));

    vct_vc_slot #(.BUF_DEPTH(BUF_DEPTH), .CNT_W(CNT_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (take_v),
      .release_vc (rel_v),
      .dec        (dec_v),
      .inc        (inc_v),
      .busy       (vc_busy[v]),
      .has_credit (vc_has_credit[v]),
      .under      (under_v[v]),
      .over       (over_v[v])
    );
  end

  assign err_d = |(under_v | over_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign credit_err = err_q;
endmodule

// File: rtl/vct_checker.sv
module vct_checker #(
  parameter int unsigned NUM_VNETS    = 3,
  parameter int unsigned VCS_PER_VNET = 2,
  parameter int unsigned NUM_VCS      = 6,
  parameter int unsigned VNET_W       = 2,
  parameter int unsigned VC_W         = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 alloc_req,
  input logic [VNET_W-1:0]    alloc_vnet,
  input logic                 alloc_gnt,
  input logic [VC_W-1:0]      alloc_vc,
  input logic [NUM_VNETS-1:0] vnet_has_free,
  input logic                 sw_grant,
  input logic [VC_W-1:0]      sw_grant_vc,
  input logic                 cr_valid,
  input logic [VC_W-1:0]      cr_vc,
  input logic                 cr_free,
  input logic [NUM_VCS-1:0]   vc_has_credit,
  input logic [NUM_VCS-1:0]   vc_busy,
  input logic                 credit_err
);
  logic [NUM_VCS-1:0] a_oh, c_oh, s_oh;
  logic               free_sel, vnet_ok, lo_ok, hi_ok;

  always_comb begin
    for (int v = 0; v < NUM_VCS; v++) begin
      a_oh[v] = (alloc_vc == VC_W'(v));
      c_oh[v] = (cr_vc == VC_W'(v));
      s_oh[v] = (sw_grant_vc == VC_W'(v));
    end
    free_sel = 1'b0;
    vnet_ok  = 1'b0;
    for (int n = 0; n < NUM_VNETS; n++) begin
      if (alloc_vnet == VNET_W'(n)) begin
        free_sel = vnet_has_free[n];
        vnet_ok  = 1'b1;
      end
    end
    lo_ok = int'(alloc_vc) >= int'(alloc_vnet) * VCS_PER_VNET;
    hi_ok = int'(alloc_vc) <  int'(alloc_vnet) * VCS_PER_VNET + VCS_PER_VNET;
  end

  assert_grant_in_vnet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_gnt |-> (lo_ok && hi_ok));

  assert_grant_follows_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && vnet_ok) |-> (alloc_gnt == free_sel));

  assert_grant_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_gnt |-> ((vc_busy & a_oh) == '0));

  assert_alloc_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_gnt |=> ((vc_busy & $past(a_oh)) != '0));

  assert_release_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_valid && cr_free && (c_oh != '0) && !(alloc_gnt && (a_oh == c_oh)))
      |=> ((vc_busy & $past(c_oh)) == '0));

  assert_credit_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_grant && !cr_valid) |=> $stable(vc_has_credit));

  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_grant && (s_oh != '0) && ((vc_has_credit & s_oh) == '0)
      && !(cr_valid && (c_oh == s_oh))) |=> credit_err);

  assert_quiet_no_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_grant && !cr_valid) |=> !credit_err);
endmodule

bind vc_credit_tracker vct_checker #(
  .NUM_VNETS    (NUM_VNETS),
  .VCS_PER_VNET (VCS_PER_VNET),
  .NUM_VCS      (NUM_VCS),
  .VNET_W       (VNET_W),
  .VC_W         (VC_W)
) u_vct_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .alloc_req     (alloc_req),
  .alloc_vnet    (alloc_vnet),
  .alloc_gnt     (alloc_gnt),
  .alloc_vc      (alloc_vc),
  .vnet_has_free (vnet_has_free),
  .sw_grant      (sw_grant),
  .sw_grant_vc   (sw_grant_vc),
  .cr_valid      (cr_valid),
  .cr_vc         (cr_vc),
  .cr_free       (cr_free),
  .vc_has_credit (vc_has_credit),
  .vc_busy       (vc_busy),
  .credit_err    (credit_err)
);

// File: tb/vc_credit_tracker_bench.sv
`timescale 1ns/1ps
module vc_credit_tracker_bench;
  localparam int NV = 3;
  localparam int K  = 2;
  localparam int D  = 4;
  localparam int NC = NV * K;

  logic          clk, rst_n;
  logic          alloc_req;
  logic [1:0]    alloc_vnet;
  logic          alloc_gnt;
  logic [2:0]    alloc_vc;
  logic [NV-1:0] vnet_has_free;
  logic          sw_grant;
  logic [2:0]    sw_grant_vc;
  logic          cr_valid;
  logic [2:0]    cr_vc;
  logic          cr_free;
  logic [NC-1:0] vc_has_credit, vc_busy;
  logic          credit_err;

  int checks = 0;
  int errors = 0;
  bit m_busy [NC];
  int m_cnt  [NC];
  bit m_err;

  vc_credit_tracker #(.NUM_VNETS(NV), .VCS_PER_VNET(K), .BUF_DEPTH(D))
    u_vc_credit_tracker (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_busy_vec();
    int r = 0;
    for (int v = 0; v < NC; v++) if (m_busy[v]) r |= (1 << v);
    return r;
  endfunction

  function automatic int exp_credit_vec();
    int r = 0;
    for (int v = 0; v < NC; v++) if (m_cnt[v] >= 1) r |= (1 << v);
    return r;
  endfunction

  function automatic int exp_free_vec();
    int r = 0;
    for (int n = 0; n < NV; n++)
      for (int i = 0; i < K; i++) if (!m_busy[n*K+i]) r |= (1 << n);
    return r;
  endfunction

  function automatic int exp_pick(input int n);
    for (int i = 0; i < K; i++) if (!m_busy[n*K+i]) return n*K + i;
    return -1;
  endfunction

  // One cycle: drive at the falling edge, check combinational outputs,
  // advance the model at the rising edge, then check registered outputs.
  task automatic step(input bit ar, input int av, input bit sg, input int sv,
                      input bit cv, input int cvc, input bit cf);
    int  pk;
    bit  g;
    alloc_req = ar; alloc_vnet = 2'(av);
    sw_grant = sg; sw_grant_vc = 3'(sv);
    cr_valid = cv; cr_vc = 3'(cvc); cr_free = cf;
    #1;
    pk = exp_pick(av);
    g  = ar && (pk >= 0);
    chk("R3", "vnet_has_free", int'(vnet_has_free), exp_free_vec());
    chk("R4", "alloc_gnt", int'(alloc_gnt), int'(g));
    if (g) chk("R2/R4", "alloc_vc", int'(alloc_vc), pk);
    chk("R8", "vc_has_credit", int'(vc_has_credit), exp_credit_vec());
    chk("R5/R7", "vc_busy", int'(vc_busy), exp_busy_vec());
    m_err = 1'b0;
    for (int v = 0; v < NC; v++) begin
      bit inc = cv && (cvc == v);
      bit dec = sg && (sv == v);
      if (inc && !dec) begin
        if (m_cnt[v] == D) m_err = 1'b1; else m_cnt[v]++;
      end else if (dec && !inc) begin
        if (m_cnt[v] == 0) m_err = 1'b1; else m_cnt[v]--;
      end
      if (inc && cf) m_busy[v] = 1'b0;
      if (g && pk == v) m_busy[v] = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    chk("R6/R9/R10", "credit_err", int'(credit_err), int'(m_err));
  endtask

  task automatic idle_step();
    step(1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b0);
  endtask

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'h5eed_1234);
    alloc_req = 0; alloc_vnet = 0; sw_grant = 0; sw_grant_vc = 0;
    cr_valid = 0; cr_vc = 0; cr_free = 0;
    for (int v = 0; v < NC; v++) begin m_busy[v] = 0; m_cnt[v] = D; end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1", "vc_busy", int'(vc_busy), 0);
    chk("R1", "vc_has_credit", int'(vc_has_credit), (1 << NC) - 1);
    chk("R1", "vnet_has_free", int'(vnet_has_free), (1 << NV) - 1);
    chk("R1", "credit_err", int'(credit_err), 0);

    // R2/R4/R5: vnet 1 hands out index 2, then 3, then nothing (R3)
    step(1, 1, 0, 0, 0, 0, 0);
    chk("R5", "vc2 busy", int'(vc_busy[2]), 1);
    step(1, 1, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0, 0);
    chk("R3", "vnet1 full", int'(vnet_has_free[1]), 0);
    // R7: release VC 3, then it is offered again
    step(0, 0, 0, 0, 1, 3, 1);
    chk("R7", "vc3 idle", int'(vc_busy[3]), 0);
    step(1, 1, 0, 0, 0, 0, 0);
    // R7: collision of release and allocation on VC 4: allocation wins
    step(1, 2, 0, 0, 1, 4, 1);
    chk("R7", "vc4 kept", int'(vc_busy[4]), 1);

    // R6/R8: drain VC 0, credit flag drops after the last one
    for (int i = 0; i < D; i++) step(0, 0, 1, 0, 0, 0, 0);
    chk("R8", "vc0 no credit", int'(vc_has_credit[0]), 0);
    // R10: underflow
    step(0, 0, 1, 0, 0, 0, 0);
    chk("R10", "underflow err", int'(credit_err), 1);
    // R9: decrement and increment together at zero
    step(0, 0, 1, 0, 1, 0, 0);
    chk("R9", "no err at zero", int'(credit_err), 0);
    chk("R9", "still empty", int'(vc_has_credit[0]), 0);
    // R10: overflow on a full VC 5, then R9 at full
    step(0, 0, 0, 0, 1, 5, 0);
    chk("R10", "overflow err", int'(credit_err), 1);
    step(0, 0, 1, 5, 1, 5, 0);
    chk("R9", "no err at full", int'(credit_err), 0);
    idle_step();

    // Constrained random traffic
    for (int t = 0; t < 3000; t++) begin
      step($urandom_range(0, 99) < 40, int'($urandom_range(0, NV - 1)),
           $urandom_range(0, 99) < 35, int'($urandom_range(0, NC - 1)),
           $urandom_range(0, 99) < 35, int'($urandom_range(0, NC - 1)),
           $urandom_range(0, 99) < 30);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule